// File: doc/BRIEF.md
# Transmit Collision Event Counter Register

This block tallies the collisions that occur while the local station is sending a frame and presents the tally as a 16-bit status word that the host can only read. The ten-bit tally sits in the upper part of the word. The lower six bits hold a fixed code that identifies which register was read. Two collision sources can feed the block: the receive activity of a twisted-pair port, and the collision pair of an attachment-unit port. Each source is asynchronous. The block synchronises both sources and detects their rising edges. A new collision is counted only while the transmit-active flag is high.

The register clears itself when the host reads it. A read returns the value held before the clear. Before the ten-bit tally can wrap, the host gets an early warning: when the enable is set, a sticky interrupt request rises as the tally steps from 511 to 512. The host then has 512 more counts in which to read the register. The request stays up until the host reads the register or pulses a separate acknowledge.

Top module: `colcnt_reg`

## Requirements
- R1: While reset is applied and after it is released, `rd_data` reads 16'h0012 (count zero).
- R2: `rd_data[5:0]` always reads the identifier 6'b010010, with bit 0 as the LSB. The tally appears in `rd_data[15:6]`.
- R3: Each rising edge of `col_tp | col_aui` that arrives while `tx_active` is high adds exactly one to the tally, however long the input stays high. The new value appears on `rd_data` after the third rising clock edge that follows the input change.
- R4: A collision edge that arrives while `tx_active` is low leaves the tally unchanged.
- R5: A cycle with `rd_sel` high returns the current tally on `rd_data`, and the tally is zero after that clock edge.
- R6: One increment from 10'h3FF wraps the tally to 10'h000.
- R7: If a counted collision edge falls in the same cycle as `rd_sel`, the read returns the pre-increment value and the tally ends that cycle at 1.
- R8: With `ovf_irq_en` high, the step of the tally from 10'h1FF to 10'h200 raises `irq`.
- R9: `irq` is sticky. Later increments keep it high. It falls after a cycle with `rd_sel` high or a cycle with `irq_ack` high.
- R10: With `ovf_irq_en` low, the 10'h1FF to 10'h200 step does not raise `irq`, and counting continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_active | input | 1 | High while a frame is being transmitted |
| col_tp | input | 1 | Collision indication from the twisted-pair receive activity (asynchronous) |
| col_aui | input | 1 | Collision indication from the attachment-unit collision pair (asynchronous) |
| rd_sel | input | 1 | One-cycle host read strobe for this register; the tally clears on it |
| ovf_irq_en | input | 1 | Enables the halfway interrupt |
| irq_ack | input | 1 | Clears the interrupt request without reading |
| rd_data | output | 16 | {tally[9:0], 6'b010010} |
| irq | output | 1 | Sticky halfway-point interrupt request |

## Verification
The hardest states to reach from the ports are the halfway crossing and the wrap. Each needs hundreds of separate collision edges, and every edge must rise, get through the synchroniser and fall again before the next one can count. The stimulus reaches them with directed bursts of short pulses that drive the tally to 10'h1FF and then to 10'h3FF. It steps across each boundary one edge at a time, with the enable set and then cleared. A read is also timed into the exact cycle in which a synchronised edge is being counted. Random sequences of reads, acknowledges and idle-time collisions cover the rest.

// File: rtl/colcnt_pkg.sv
`timescale 1ns/1ps
package colcnt_pkg;
  localparam int unsigned CNT_W_DEF  = 10;
  localparam int unsigned ID_W       = 6;
  localparam logic [ID_W-1:0] ID_CODE_DEF = 6'b010010;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/colcnt_rst_sync.sv
`timescale 1ns/1ps
module colcnt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/colcnt_evt_detect.sv
`timescale 1ns/1ps
module colcnt_evt_detect #(
  parameter int unsigned NSRC   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] col_in,
  input  logic            tx_active,
  output logic            evt
);
  logic              any_col;
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  assign any_col = |col_in;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], any_col};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign evt = sync_q[STAGES-1] & ~prev_q & tx_active;
endmodule

// File: rtl/colcnt_counter.sv
`timescale 1ns/1ps
module colcnt_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             half_cross
);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (CNT_W-1)) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc | clr;
    cnt_d  = cnt_q;
    if (clr)      cnt_d = inc ? CNT_W'(1) : '0;
    else if (inc) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt        = cnt_q;
  assign half_cross = inc & ~clr & (cnt_q == HALF_M1);
endmodule

// File: rtl/colcnt_irq.sv
`timescale 1ns/1ps
module colcnt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic enable,
  input  logic clr,
  output logic irq
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr)           irq_d = 1'b0;
    if (set && enable) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/colcnt_reg.sv
`timescale 1ns/1ps
module colcnt_reg
  import colcnt_pkg::*;
#(
  parameter int unsigned     CNT_W   = CNT_W_DEF,
  parameter int unsigned     SYNC    = SYNC_DEF,
  parameter logic [ID_W-1:0] ID_CODE = ID_CODE_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_active,
  input  logic                  col_tp,
  input  logic                  col_aui,
  input  logic                  rd_sel,
  input  logic                  ovf_irq_en,
  input  logic                  irq_ack,
  output logic [CNT_W+ID_W-1:0] rd_data,
  output logic                  irq
);
  localparam int unsigned NSRC = 2;

  logic             rst_n_sync;
  logic             col_evt;
  logic [CNT_W-1:0] count;
  logic             half_cross;

  colcnt_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  colcnt_evt_detect #(.NSRC(NSRC), .STAGES(SYNC)) u_evt (
    .clk(clk), .rst_n(rst_n_sync), .col_in({col_aui, col_tp}),
    .tx_active(tx_active), .evt(col_evt)
  );

  colcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .inc(col_evt), .clr(rd_sel),
    .cnt(count), .half_cross(half_cross)
  );

  colcnt_irq u_irq (
    .clk(clk), .rst_n(rst_n_sync), .set(half_cross), .enable(ovf_irq_en),
    .clr(rd_sel | irq_ack), .irq(irq)
  );

  assign rd_data = {count, ID_CODE};
endmodule

// File: rtl/colcnt_chk.sv
`timescale 1ns/1ps
module colcnt_chk
  import colcnt_pkg::*;
#(
  parameter int unsigned     CNT_W   = CNT_W_DEF,
  parameter logic [ID_W-1:0] ID_CODE = ID_CODE_DEF
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  evt,
  input logic                  rd_sel,
  input logic                  irq_ack,
  input logic                  ovf_irq_en,
  input logic [CNT_W+ID_W-1:0] rd_data,
  input logic                  irq
);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (CNT_W-1)) - 1);

  logic [CNT_W-1:0] cnt;
  logic             crossing;
  assign cnt      = rd_data[CNT_W+ID_W-1:ID_W];
  assign crossing = ovf_irq_en && evt && !rd_sel && (cnt == HALF_M1);

  p_id_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ID_W-1:0] == ID_CODE);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !rd_sel) |=> cnt == $past(cnt) + CNT_W'(1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !rd_sel) |=> $stable(cnt));

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && !evt) |=> cnt == '0);

  p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && evt) |=> cnt == CNT_W'(1));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    crossing |=> irq);

  p_irq_read_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> !irq);

  p_irq_ack_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !crossing) |=> !irq);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ovf_irq_en) |=> !irq);
endmodule

bind colcnt_reg colcnt_chk #(.CNT_W(CNT_W), .ID_CODE(ID_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .evt(col_evt), .rd_sel(rd_sel),
  .irq_ack(irq_ack), .ovf_irq_en(ovf_irq_en), .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_colcnt_reg.sv
`timescale 1ns/1ps
module sim_colcnt_reg;
  localparam int CW = 10;
  localparam logic [5:0] ID = 6'b010010;

  logic clk = 1'b0;
  logic rst_n, tx_active, col_tp, col_aui, rd_sel, ovf_irq_en, irq_ack;
  logic [15:0] rd_data;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [CW-1:0] exp_cnt;
  logic exp_irq;

  always #2.5 clk = ~clk;

  colcnt_reg u0 (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .col_tp(col_tp),
    .col_aui(col_aui), .rd_sel(rd_sel), .ovf_irq_en(ovf_irq_en),
    .irq_ack(irq_ack), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [15:0] f_word(input logic [CW-1:0] c);
    return {c, ID};
  endfunction

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rd_data act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk16(req, rd_data, f_word(exp_cnt));
    chk1(req, irq, exp_irq);
  endtask

  // one collision pulse; afterwards all effects have settled
  task automatic pulse(input bit src, input int len, input bit tx);
    @(negedge clk);
    tx_active = tx;
    if (src) col_aui = 1'b1; else col_tp = 1'b1;
    repeat (len) @(negedge clk);
    col_tp = 1'b0; col_aui = 1'b0;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
    if (tx) begin
      if (exp_cnt == 10'h1FF && ovf_irq_en) exp_irq = 1'b1;
      exp_cnt = exp_cnt + 1'b1;
    end
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    rd_sel = 1'b1;
    chk16(req, rd_data, f_word(exp_cnt));
    @(negedge clk);
    rd_sel = 1'b0;
    exp_cnt = '0; exp_irq = 1'b0;
    check_state(req);
  endtask

  task automatic do_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    exp_irq = 1'b0;
  endtask

  task automatic pump(input int n);
    for (int i = 0; i < n; i++) pulse(i[0], 1, 1'b1);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; tx_active = 1'b0; col_tp = 1'b0; col_aui = 1'b0;
    rd_sel = 1'b0; ovf_irq_en = 1'b0; irq_ack = 1'b0;
    exp_cnt = '0; exp_irq = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after reset");

    // R3: latency of three edges, long pulse counts once
    @(negedge clk);
    tx_active = 1'b1; col_tp = 1'b1;
    @(negedge clk); @(negedge clk);
    chk16("R3 before third edge", rd_data, f_word(0));
    @(negedge clk);
    chk16("R3 after third edge", rd_data, f_word(1));
    repeat (10) @(negedge clk);
    col_tp = 1'b0;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
    exp_cnt = 1;
    check_state("R3 long pulse once");
    pulse(1'b1, 2, 1'b1);
    check_state("R3 aui source");
    // R4
    pulse(1'b0, 2, 1'b0);
    check_state("R4 idle collision ignored");
    // R5
    do_read("R5 read clears");

    // R7: read in the same cycle as a counted edge
    pump(3);
    @(negedge clk);
    tx_active = 1'b1; col_aui = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_sel = 1'b1;
    chk16("R7 read returns pre-increment", rd_data, f_word(3));
    @(negedge clk);
    rd_sel = 1'b0;
    col_aui = 1'b0;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
    exp_cnt = 1;
    check_state("R7 ends at one");
    do_read("R5 read after coincide");

    // R8 / R9 halfway interrupt
    ovf_irq_en = 1'b1;
    pump(511);
    check_state("R8 at 1FF no irq");
    pulse(1'b0, 1, 1'b1);
    check_state("R8 irq at 200");
    pulse(1'b1, 3, 1'b1);
    check_state("R9 irq sticky");
    do_ack();
    check_state("R9 ack clears");
    // R6 wrap
    pump(10'h3FF - 10'h201);
    check_state("R6 at 3FF");
    pulse(1'b0, 1, 1'b1);
    check_state("R6 wraps to zero");
    // R10 enable cleared
    ovf_irq_en = 1'b0;
    pump(512);
    check_state("R10 no irq when disabled");
    pulse(1'b1, 1, 1'b1);
    check_state("R10 counting continues");
    // R9 read clears irq
    do_read("R9 read setup");
    ovf_irq_en = 1'b1;
    pump(512);
    check_state("R8 irq again");
    do_read("R9 read clears irq");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 10);
      ovf_irq_en = ($urandom % 2) != 0;
      if (op == 0) do_read("R5 random read");
      else if (op == 1) begin do_ack(); check_state("R9 random ack"); end
      else begin
        pulse(($urandom % 2) != 0, 1 + int'($urandom % 4), ($urandom % 4) != 0);
        check_state("R3 R4 random pulse");
      end
      chk16("R2 id bits", {10'd0, rd_data[5:0]}, {10'd0, ID});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule